// File: doc/BRIEF.md
# Tick Counter Bank with Compare Interrupt

This block holds three identical cycle counters, one per execution level of a processor: a basic tick, a system tick and a hypervisor tick. Each counter advances by one on every cycle in which the shared tick strobe is high, which the surrounding logic drives at the nominal 100 MHz counting rate. Each counter has a compare limit; when the counter climbs onto an armed limit, the block emits a one-cycle set pulse toward the soft-interrupt register, which owns the clearing of the bit.

Software reaches the counters through a small register interface. A write picks one counter and one of two targets, the count or the limit, and a separate read port returns any counter's value one cycle after it is selected. The most significant bit of every 64-bit word is a flag and not part of the value: on the count it marks that user-level reads should trap, and on the limit it switches the compare off. A limit of zero never arms the compare. A limit that the counter has already reached or passed fires on the next tick, so no wrap of the counter is needed.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every counter reads 0x8000_0000_0000_0000 (value 0, trap flag set), every compare is disabled with a zero limit, and both set pulses are low.
- R2: A write with wr_kind = 0 to the counter chosen by wr_sel (0 tick, 1 system tick, 2 hypervisor tick, 3 nothing) loads bits 62:0 into the counter and keeps bit 63 as the trap flag.
- R3: A read selects a counter with rd_sel; on the next clock rd_data shows bit 63 = trap flag and bits 62:0 = the count as it stood at that clock edge. rd_sel = 3 returns zero.
- R4: A counter advances by exactly one on each clock with tick_en high, holds otherwise, and wraps from 0x7FFF_FFFF_FFFF_FFFF to 0.
- R5: A write with wr_kind = 1 stores bits 62:0 as the limit and bit 63 as the disable flag (1 = disabled).
- R6: With the compare armed, the clock edge at which the counter steps onto the limit also raises the set pulse for exactly one cycle.
- R7: A zero limit or a set disable flag produces no set pulse, even when the counter passes the limit or wraps through zero.
- R8: If a limit write leaves the limit at or below the counter value after that clock, the set pulse follows at the next tick, and only once.
- R9: Counter 0 drives soft_timer_set; counters 1 and 2 both drive soft_stimer_set.
- R10: A count write and a tick in the same cycle load the written value without incrementing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Counter chosen by the write |
| wr_kind | input | 1 | 0 writes the count, 1 writes the limit |
| wr_data | input | 64 | Write word, bit 63 is the flag |
| rd_sel | input | 2 | Counter chosen by the read |
| rd_data | output | 64 | Registered read word |
| soft_timer_set | output | 1 | Set pulse for the timer soft-interrupt bit |
| soft_stimer_set | output | 1 | Set pulse for the system-timer soft-interrupt bit |

## Verification
The case that matters most is a register write landing in the same cycle as a tick. The bench writes a limit of 51 while the counter sits at 50 and tick_en is high, so the counter steps to 51 at the very edge that takes the new limit. The correct outcome is no pulse at that edge and one pulse at the next tick, through the already-reached path. A count write issued with tick_en high must read back as the written value, not that value plus one.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int NUM_UNITS = 3;
  localparam int SEL_W     = 2;

  typedef enum logic {
    KIND_COUNT = 1'b0,
    KIND_LIMIT = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/tick_unit.sv
module tick_unit #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_cnt,
  input  logic             wr_lim,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W:0]   cnt_word,
  output logic             fire_o
);
  localparam int FLAG = CNT_W;

  logic [CNT_W-1:0] cnt_q, lim_q, cnt_inc, cnt_nxt, new_lim;
  logic             trap_q, dis_q, late_q, fire_q, armed;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_nxt = wr_cnt  ? wr_data[CNT_W-1:0] :
                   tick_en ? cnt_inc : cnt_q;
  assign new_lim = wr_data[CNT_W-1:0];
  assign armed   = !dis_q && (lim_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      trap_q <= 1'b1;
      dis_q  <= 1'b1;
      late_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      fire_q <= 1'b0;
      if (wr_cnt) trap_q <= wr_data[FLAG];
      if (wr_lim) begin
        lim_q  <= new_lim;
        dis_q  <= wr_data[FLAG];
        late_q <= !wr_data[FLAG] && (new_lim != '0) && (new_lim <= cnt_nxt);
      end else if (tick_en && !wr_cnt && armed) begin
        if (late_q || (cnt_inc == lim_q)) fire_q <= 1'b1;
        late_q <= 1'b0;
      end
    end
  end

  assign cnt_word = {trap_q, cnt_q};
  assign fire_o   = fire_q;

  // R4: one step per tick, wrapping
  assert_tick_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4: no tick, no write, no change
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_cnt) |=> $stable(cnt_q));
  // R7: a disarmed compare never fires
  assert_no_fire_disarmed_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_lim && (dis_q || lim_q == '0)) |=> !fire_q);
  // R8: a pending late match fires on the next tick
  assert_late_fires_R8: assert property (@(posedge clk) disable iff (rst)
    (late_q && armed && tick_en && !wr_cnt && !wr_lim) |=> fire_q);
  // R6: a pulse lasts one cycle
  assert_pulse_one_R6: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);
endmodule

// File: rtl/tick_rd_mux.sv
module tick_rd_mux #(
  parameter int N     = 3,
  parameter int W     = 64,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [N*W-1:0]   words,
  output logic [W-1:0]     rd_q
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++)
      if (sel == SEL_W'(i)) pick = words[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= pick;
  end
endmodule

// File: rtl/tick_soft_merge.sv
module tick_soft_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] fire,
  output logic         timer_set,
  output logic         stimer_set
);
  logic [N-1:0] sys_mask;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mask
      assign sys_mask[g] = (g != 0) && fire[g];
    end
  endgenerate

  assign timer_set  = fire[0];
  assign stimer_set = |sys_mask;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int CNT_W = 63
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_en,
  input  logic                        wr_en,
  input  logic [tick_pkg::SEL_W-1:0]  wr_sel,
  input  logic                        wr_kind,
  input  logic [CNT_W:0]              wr_data,
  input  logic [tick_pkg::SEL_W-1:0]  rd_sel,
  output logic [CNT_W:0]              rd_data,
  output logic                        soft_timer_set,
  output logic                        soft_stimer_set
);
  import tick_pkg::*;
  localparam int WORD_W = CNT_W + 1;
  localparam int N      = NUM_UNITS;

  logic [N*WORD_W-1:0] words;
  logic [N-1:0]        fire;

  genvar u;
  generate
    for (u = 0; u < N; u++) begin : g_unit
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(u));
      tick_unit #(.CNT_W(CNT_W)) u_unit (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .wr_cnt   (hit && (wr_kind == KIND_COUNT)),
        .wr_lim   (hit && (wr_kind == KIND_LIMIT)),
        .wr_data  (wr_data),
        .cnt_word (words[u*WORD_W +: WORD_W]),
        .fire_o   (fire[u])
      );
    end
  endgenerate

  tick_rd_mux #(.N(N), .W(WORD_W), .SEL_W(SEL_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (rd_sel),
    .words (words),
    .rd_q  (rd_data)
  );

  tick_soft_merge #(.N(N)) u_merge (
    .fire       (fire),
    .timer_set  (soft_timer_set),
    .stimer_set (soft_stimer_set)
  );

  // R9: the timer line follows only counter 0
  assert_timer_map_R9: assert property (@(posedge clk) disable iff (rst)
    soft_timer_set |-> fire[0]);
  // R1: outputs quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!soft_timer_set && !soft_stimer_set));
endmodule

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_kind = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        soft_timer_set, soft_stimer_set;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_bank u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_kind(wr_kind), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .soft_timer_set(soft_timer_set), .soft_stimer_set(soft_stimer_set)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit t);
    tick_en = t;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, bit kind, logic [63:0] d, bit t);
    wr_en = 1'b1; wr_sel = sel; wr_kind = kind; wr_data = d; tick_en = t;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [63:0] v);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), v);
      check("R1 reset count word", v, FLAG);
    end
    check("R1 timer pulse low", {63'b0, soft_timer_set}, 64'd0);
    check("R1 stimer pulse low", {63'b0, soft_stimer_set}, 64'd0);
    rd(2'd3, v);
    check("R3 unused select reads zero", v, 64'd0);
  endtask

  task automatic t_count_write();
    logic [63:0] v;
    wr(0, 0, 64'h1234, 0);
    rd(0, v);
    check("R2 count load, flag clear", v, 64'h1234);
    wr(0, 0, FLAG | 64'd5, 0);
    rd(0, v);
    check("R2 R3 count load with trap flag", v, FLAG | 64'd5);
    wr(0, 0, 64'd7, 1);
    rd(0, v);
    check("R10 write beats tick", v, 64'd7);
  endtask

  task automatic t_advance();
    logic [63:0] v;
    wr(0, 0, 64'd1000, 0);
    for (int k = 0; k < 10; k++) cyc(1);
    cyc(0);
    rd(0, v);
    check("R4 ten ticks", v, 64'd1010);
  endtask

  task automatic t_match();
    wr(0, 0, 64'd100, 0);
    wr(0, 1, 64'd105, 0);
    for (int k = 1; k <= 7; k++) begin
      cyc(1);
      check("R6 match pulse timing", {63'b0, soft_timer_set}, (k == 5) ? 64'd1 : 64'd0);
      check("R9 stimer quiet on tick match", {63'b0, soft_stimer_set}, 64'd0);
    end
  endtask

  task automatic t_disabled();
    logic [63:0] v;
    int seen = 0;
    wr(0, 0, 64'd10, 0);
    wr(0, 1, FLAG | 64'd12, 0);
    for (int k = 0; k < 5; k++) begin
      cyc(1);
      if (soft_timer_set) seen++;
    end
    check("R5 R7 disabled limit silent", 64'(seen), 64'd0);
    rd(0, v);
    check("R4 count after disabled run", v, 64'd15);
  endtask

  task automatic t_late();
    wr(0, 0, 64'd200, 0);
    wr(0, 1, 64'd150, 0);
    check("R8 no pulse at limit write", {63'b0, soft_timer_set}, 64'd0);
    cyc(0);
    check("R8 no pulse without tick", {63'b0, soft_timer_set}, 64'd0);
    cyc(1);
    check("R8 passed limit fires next tick", {63'b0, soft_timer_set}, 64'd1);
    cyc(1);
    check("R8 passed limit fires once", {63'b0, soft_timer_set}, 64'd0);
  endtask

  task automatic t_same_cycle();
    logic [63:0] v;
    wr(0, 0, 64'd50, 0);
    wr(0, 1, 64'd51, 1);
    check("R8 limit write with tick: no pulse yet", {63'b0, soft_timer_set}, 64'd0);
    cyc(1);
    check("R8 limit write with tick: pulse next tick", {63'b0, soft_timer_set}, 64'd1);
    rd(0, v);
    check("R4 count after collision", v, 64'd52);
  endtask

  task automatic t_zero_wrap();
    logic [63:0] v;
    int seen = 0;
    wr(0, 1, 64'd0, 0);
    wr(0, 0, 64'h7FFF_FFFF_FFFF_FFFE, 0);
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      if (soft_timer_set) seen++;
    end
    check("R7 zero limit silent across wrap", 64'(seen), 64'd0);
    rd(0, v);
    check("R4 wrap to zero", v, 64'd1);
  endtask

  task automatic t_system(logic [1:0] sel);
    wr(sel, 0, 64'd0, 0);
    wr(sel, 1, 64'd3, 0);
    for (int k = 1; k <= 4; k++) begin
      cyc(1);
      check("R9 system tick drives stimer", {63'b0, soft_stimer_set}, (k == 3) ? 64'd1 : 64'd0);
      check("R9 system tick leaves timer", {63'b0, soft_timer_set}, 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_write();
    t_advance();
    t_match();
    t_disabled();
    t_late();
    t_same_cycle();
    t_zero_wrap();
    t_system(2'd1);
    t_system(2'd2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule